// File: doc/BRIEF.md
# Grouped interrupt cause aggregator

This block folds a set of interrupt sources into two 32-bit main cause words, a low word and a high word, and drives one interrupt request line toward a CPU. The sources are a 32-bit pin cause register with its own writable mask, and a serial-DMA cause vector supplied from outside. The pin cause is changed by single-bit set and clear strobes that carry a bit index, or by a whole-word load. The pin causes are not reported bit by bit. Each 8-bit group of masked pin causes raises one summary bit in the high word, and any nonzero DMA cause raises a single summary bit. No source currently feeds the low word. The request line is the OR, taken across both words, of each cause word ANDed with the matching CPU mask word.

Software reaches the masks and the cause words through a small register port. A command is a valid strobe, a write flag, an address and write data. The port has no back-pressure: it accepts every command in the cycle it is presented. The response to a read appears on the next clock edge, with a one-cycle response strobe, and software cannot stall it. The cause words are recomputed from their sources at all times and cannot be written.

Top module: `irq_cause_agg`

## Requirements
- R1: High cause bits 24, 25, 26 and 27 are set when (pin cause AND pin mask) is nonzero in pin bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R2: High cause bit 4 is set when the DMA cause input is nonzero. All high cause bits other than 4 and 24 to 27 read 0, and the low cause word always reads 0.
- R3: `irq` is registered. On each clock it takes the value ((cause low AND mask low) != 0) OR ((cause high AND mask high) != 0), evaluated on the state before that edge. It therefore follows a change in a cause or mask register one cycle after that register changes.
- R4: The register map is as follows. Cause low is at 0x0004 and cause high at 0x000C. Mask low is at 0x0014 and mask high at 0x001C. Pin cause is at 0xF108 and pin mask at 0xF10C. Both CPU masks and the pin mask can be read and written.
- R5: A read command presented at a clock edge produces `rsp_valid`=1 and `rsp_data` on the next edge. The returned value is the register value as it stood at the command edge. `rsp_valid` is 0 in every other cycle.
- R6: Writes to the cause low, cause high and pin cause addresses are ignored.
- R7: Reads of any unmapped address return 0, and writes to unmapped addresses change no register.
- R8: `pin_set` sets pin cause bit `pin_idx`. `pin_clr` clears that bit. When both are asserted in the same cycle, the clear wins.
- R9: `pin_load` replaces the whole pin cause word with `pin_load_val`. It takes priority over `pin_set` and `pin_clr` asserted in the same cycle.
- R10: After reset, all masks and the pin cause are 0, `irq` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Register command present, always accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register byte address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read command |
| rsp_data | output | 32 | Read data |
| pin_set | input | 1 | Set pin cause bit `pin_idx` |
| pin_clr | input | 1 | Clear pin cause bit `pin_idx` |
| pin_idx | input | 5 | Bit index for set and clear |
| pin_load | input | 1 | Load the whole pin cause word |
| pin_load_val | input | 32 | Value for the whole-word load |
| dma_cause | input | 8 | Serial-DMA cause vector |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Register effects are due at different times. A write, strobe or load changes its register at the first edge that samples it. Read data is due on the edge after the command. `irq` is due one edge after the register it depends on changes. The bench therefore drives inputs at falling edges and reads the response at the next falling edge. It checks `irq` two falling edges after a stimulus, or one and then two falling edges after it when it checks the exact latency. Each table row lets the sources settle before the high cause word is read back and `irq` is compared, so every result is sampled only after the cycle in which it becomes due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] A_CAUSE_LO  = 16'h0004;
  localparam logic [ADDR_W-1:0] A_CAUSE_HI  = 16'h000C;
  localparam logic [ADDR_W-1:0] A_MASK_LO   = 16'h0014;
  localparam logic [ADDR_W-1:0] A_MASK_HI   = 16'h001C;
  localparam logic [ADDR_W-1:0] A_PIN_CAUSE = 16'hF108;
  localparam logic [ADDR_W-1:0] A_PIN_MASK  = 16'hF10C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAUSE_LO,
    SEL_CAUSE_HI,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_PIN_CAUSE,
    SEL_PIN_MASK
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      A_CAUSE_LO:  s = SEL_CAUSE_LO;
      A_CAUSE_HI:  s = SEL_CAUSE_HI;
      A_MASK_LO:   s = SEL_MASK_LO;
      A_MASK_HI:   s = SEL_MASK_HI;
      A_PIN_CAUSE: s = SEL_PIN_CAUSE;
      A_PIN_MASK:  s = SEL_PIN_MASK;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irq_agg_pinreg.sv
module irq_agg_pinreg #(
  parameter int unsigned PIN_W = 32,
  localparam int unsigned IDX_W = $clog2(PIN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             load_i,
  input  logic [PIN_W-1:0] load_val_i,
  output logic [PIN_W-1:0] cause_o
);
  logic [PIN_W-1:0] onehot;
  logic [PIN_W-1:0] nxt;

  always_comb begin
    onehot = '0;
    onehot[idx_i] = 1'b1;
    nxt = cause_o;
    if (load_i) begin
      nxt = load_val_i;
    end else begin
      if (set_i) nxt = nxt | onehot;
      if (clr_i) nxt = nxt & ~onehot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_o <= '0;
    else        cause_o <= nxt;
  end
endmodule

// File: rtl/irq_agg_summary.sv
module irq_agg_summary #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PIN_W      = 32,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned GROUP_BASE = 24,
  parameter int unsigned DMA_W      = 8,
  parameter int unsigned DMA_BIT    = 4,
  localparam int unsigned N_GROUPS  = PIN_W / GROUP_W
) (
  input  logic [PIN_W-1:0]  pin_cause_i,
  input  logic [PIN_W-1:0]  pin_mask_i,
  input  logic [DMA_W-1:0]  dma_cause_i,
  output logic [WORD_W-1:0] cause_lo_o,
  output logic [WORD_W-1:0] cause_hi_o
);
  logic [PIN_W-1:0]    active;
  logic [N_GROUPS-1:0] grp_hit;

  assign active = pin_cause_i & pin_mask_i;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |active[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    cause_hi_o = '0;
    cause_hi_o[GROUP_BASE +: N_GROUPS] = grp_hit;
    cause_hi_o[DMA_BIT] = |dma_cause_i;
  end

  assign cause_lo_o = '0;
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [WORD_W-1:0] cause_lo_i,
  input  logic [WORD_W-1:0] cause_hi_i,
  input  logic [PIN_W-1:0]  pin_cause_i,
  output logic [WORD_W-1:0] mask_lo_o,
  output logic [WORD_W-1:0] mask_hi_o,
  output logic [PIN_W-1:0]  pin_mask_o,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  reg_sel_e          sel;
  logic [WORD_W-1:0] rd_mux;

  assign sel = decode_addr(cmd_addr);

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CAUSE_LO:  rd_mux = cause_lo_i;
      SEL_CAUSE_HI:  rd_mux = cause_hi_i;
      SEL_MASK_LO:   rd_mux = mask_lo_o;
      SEL_MASK_HI:   rd_mux = mask_hi_o;
      SEL_PIN_CAUSE: rd_mux = WORD_W'(pin_cause_i);
      SEL_PIN_MASK:  rd_mux = WORD_W'(pin_mask_o);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo_o  <= '0;
      mask_hi_o  <= '0;
      pin_mask_o <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= cmd_valid && !cmd_write;
      if (cmd_valid && !cmd_write) rsp_data <= rd_mux;
      if (cmd_valid && cmd_write) begin
        case (sel)
          SEL_MASK_LO:  mask_lo_o  <= cmd_wdata;
          SEL_MASK_HI:  mask_hi_o  <= cmd_wdata;
          SEL_PIN_MASK: pin_mask_o <= cmd_wdata[PIN_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned PIN_W      = 32,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned GROUP_BASE = 24,
  parameter int unsigned DMA_W      = 8,
  parameter int unsigned DMA_BIT    = 4,
  localparam int unsigned IDX_W     = $clog2(PIN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              pin_set,
  input  logic              pin_clr,
  input  logic [IDX_W-1:0]  pin_idx,
  input  logic              pin_load,
  input  logic [PIN_W-1:0]  pin_load_val,
  input  logic [DMA_W-1:0]  dma_cause,
  output logic              irq
);
  logic [PIN_W-1:0]  pin_cause;
  logic [PIN_W-1:0]  pin_mask;
  logic [WORD_W-1:0] cause_lo;
  logic [WORD_W-1:0] cause_hi;
  logic [WORD_W-1:0] mask_lo;
  logic [WORD_W-1:0] mask_hi;

  irq_agg_pinreg #(.PIN_W(PIN_W)) u_pin (
    .clk(clk), .rst_n(rst_n),
    .set_i(pin_set), .clr_i(pin_clr), .idx_i(pin_idx),
    .load_i(pin_load), .load_val_i(pin_load_val),
    .cause_o(pin_cause)
  );

  irq_agg_summary #(
    .WORD_W(WORD_W), .PIN_W(PIN_W), .GROUP_W(GROUP_W),
    .GROUP_BASE(GROUP_BASE), .DMA_W(DMA_W), .DMA_BIT(DMA_BIT)
  ) u_sum (
    .pin_cause_i(pin_cause), .pin_mask_i(pin_mask), .dma_cause_i(dma_cause),
    .cause_lo_o(cause_lo), .cause_hi_o(cause_hi)
  );

  irq_agg_regs #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cause_lo_i(cause_lo), .cause_hi_i(cause_hi), .pin_cause_i(pin_cause),
    .mask_lo_o(mask_lo), .mask_hi_o(mask_hi), .pin_mask_o(pin_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (|(cause_lo & mask_lo)) || (|(cause_hi & mask_hi));
  end
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_write,
  input logic [15:0] cmd_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        pin_set,
  input logic        pin_clr,
  input logic [4:0]  pin_idx,
  input logic        pin_load,
  input logic [31:0] pin_cause,
  input logic [31:0] cause_hi,
  input logic [31:0] mask_hi,
  input logic        irq
);
  // R3
  irq_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_hi & mask_hi) != 32'h0) |=> irq);

  // R5
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rsp_valid);

  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rsp_valid);

  // R2
  cause_lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_addr == 16'h0004) |=> (rsp_data == 32'h0));

  // R2
  cause_hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_addr == 16'h000C) |=> ((rsp_data & 32'hF0FF_FFEF) == 32'h0));

  // R8
  pin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clr && !pin_load) |=> (pin_cause[$past(pin_idx)] == 1'b0));

  // R8
  pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_set && !pin_clr && !pin_load) |=> (pin_cause[$past(pin_idx)] == 1'b1));
endmodule

bind irq_cause_agg irq_cause_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .pin_set(pin_set), .pin_clr(pin_clr), .pin_idx(pin_idx), .pin_load(pin_load),
  .pin_cause(pin_cause), .cause_hi(cause_hi), .mask_hi(mask_hi), .irq(irq)
);

// File: tb/irq_cause_agg_test.sv
module irq_cause_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        pin_set = 1'b0;
  logic        pin_clr = 1'b0;
  logic [4:0]  pin_idx = '0;
  logic        pin_load = 1'b0;
  logic [31:0] pin_load_val = '0;
  logic [7:0]  dma_cause = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_agg uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pin_set(pin_set), .pin_clr(pin_clr), .pin_idx(pin_idx),
    .pin_load(pin_load), .pin_load_val(pin_load_val), .dma_cause(dma_cause),
    .irq(irq)
  );

  localparam logic [15:0] CLO = 16'h0004, CHI = 16'h000C, MLO = 16'h0014,
                          MHI = 16'h001C, PCA = 16'hF108, PMK = 16'hF10C;

  localparam int NV = 6;
  localparam logic [31:0] V_PIN  [NV] = '{32'h0000_00FF, 32'hFF00_0000, 32'h0001_0100,
                                          32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_PMSK [NV] = '{32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h0001_0100,
                                          32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_MHI  [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0400_0000,
                                          32'h0000_0010, 32'h0000_0010, 32'h0000_0000};
  localparam logic [7:0]  V_DMA  [NV] = '{8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h01};
  localparam logic [31:0] V_EHI  [NV] = '{32'h0100_0000, 32'h0000_0000, 32'h0600_0000,
                                          32'h0000_0010, 32'h0800_0000, 32'h0F00_0010};
  localparam logic        V_EIRQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rsp_data;
    check("R5 rsp_valid", {31'h0, rsp_valid}, 32'h1);
  endtask

  task automatic load_pins(input logic [31:0] v);
    pin_load = 1'b1; pin_load_val = v;
    @(negedge clk);
    pin_load = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq", {31'h0, irq}, 32'h0);
    check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rd(MHI, d); check("R10 mask_hi", d, 32'h0);
    rd(MLO, d); check("R10 mask_lo", d, 32'h0);
    rd(PMK, d); check("R10 pin_mask", d, 32'h0);
    rd(PCA, d); check("R10 pin_cause", d, 32'h0);

    // R1 R2 R3 table walk
    for (int v = 0; v < NV; v++) begin
      wr(PMK, V_PMSK[v]);
      wr(MHI, V_MHI[v]);
      dma_cause = V_DMA[v];
      load_pins(V_PIN[v]);
      idle(1);
      rd(CHI, d);
      check($sformatf("R1 R2 cause_hi row %0d", v), d, V_EHI[v]);
      check($sformatf("R3 irq row %0d", v), {31'h0, irq}, {31'h0, V_EIRQ[v]});
    end
    dma_cause = 8'h00;

    // R4 mask readback
    wr(MLO, 32'hA5A5_5A5A);
    rd(MLO, d); check("R4 mask_lo readback", d, 32'hA5A5_5A5A);
    rd(PMK, d); check("R4 pin_mask readback", d, 32'hFFFF_FFFF);

    // R2 low word zero: with low mask all ones and high mask zero, irq stays low
    wr(MLO, 32'hFFFF_FFFF);
    wr(MHI, 32'h0);
    idle(2);
    rd(CLO, d); check("R2 cause_lo zero", d, 32'h0);
    check("R2 irq with only low mask", {31'h0, irq}, 32'h0);

    // R3 exact latency
    wr(MHI, 32'h0100_0000);
    load_pins(32'h0);
    idle(2);
    check("R3 irq before set", {31'h0, irq}, 32'h0);
    pin_set = 1'b1; pin_idx = 5'd3;
    @(negedge clk);
    pin_set = 1'b0;
    check("R3 irq not yet one cycle", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R3 irq after one cycle", {31'h0, irq}, 32'h1);

    // R8 clear, and clear wins over set
    pin_clr = 1'b1; pin_idx = 5'd3;
    @(negedge clk);
    pin_clr = 1'b0;
    rd(PCA, d); check("R8 clear bit 3", d, 32'h0);
    pin_set = 1'b1; pin_idx = 5'd31;
    @(negedge clk);
    pin_idx = 5'd5; pin_clr = 1'b1;
    @(negedge clk);
    pin_set = 1'b0; pin_clr = 1'b0;
    rd(PCA, d); check("R8 clear wins", d, 32'h8000_0000);

    // R9 load priority
    pin_load = 1'b1; pin_load_val = 32'h0000_00F0; pin_set = 1'b1; pin_idx = 5'd0;
    @(negedge clk);
    pin_load = 1'b0; pin_set = 1'b0;
    rd(PCA, d); check("R9 load priority", d, 32'h0000_00F0);

    // R6 cause and pin-cause writes ignored
    wr(CHI, 32'h0);
    rd(CHI, d); check("R6 cause_hi write ignored", d, 32'h0100_0000);
    wr(CLO, 32'hFFFF_FFFF);
    rd(CLO, d); check("R6 cause_lo write ignored", d, 32'h0);
    wr(PCA, 32'hFFFF_FFFF);
    rd(PCA, d); check("R6 pin_cause write ignored", d, 32'h0000_00F0);

    // R7 unmapped
    wr(16'h0018, 32'hDEAD_BEEF);
    rd(16'h0018, d); check("R7 unmapped read", d, 32'h0);
    rd(MHI, d); check("R7 mask_hi untouched", d, 32'h0100_0000);
    rd(MLO, d); check("R7 mask_lo untouched", d, 32'hFFFF_FFFF);

    done = 1'b1;
    report();
  end
endmodule